// File: doc/BRIEF.md
# Scatter-Gather DMA Channel

This block is a single DMA channel that moves data by walking a chain of transfer descriptors kept in a small internal descriptor memory. Each descriptor names a source and a destination address, says whether each address advances, and gives a beat width, a burst length, a byte count and the index of the next descriptor. Software (or a neighbouring block) writes the descriptors through a write port, then starts the channel by giving the index of the first one. From there on the engine fetches each descriptor, moves its bytes and follows the links without further help.

Data moves in bursts. A burst starts only when the peripheral's transfer-request line is high. Once a burst starts, it runs as back-to-back read/write beat pairs on a simple valid/ready memory port until it reaches its beat count or the descriptor runs out of bytes. A null link ends the chain. In ring mode the engine instead wraps to the first descriptor and keeps going, which suits a peripheral that streams through a circular buffer. A residue output tells how many bytes are still to move. Its update granularity is chosen by a parameter.

Top module: `sg_dma_chan`

## Requirements
- R1: After a synchronous reset, `busy`, `done` and `mem_req` are 0, and `residue` is 0.
- R2: A descriptor is a 60-bit word written at `dsc_addr` while `dsc_wr` is 1. The fields are, from bit 0 upward:
  - next index [3:0]
  - byte count [19:4]
  - burst code [23:20]
  - width code [25:24]
  - destination-advance flag [26]
  - source-advance flag [27]
  - destination address [43:28]
  - source address [59:44]

  A one-cycle `go` in idle starts the chain at descriptor `go_idx`.
- R3: Each beat reads `mem_size`+1 bytes at the source and then writes those same bytes, on the low byte lanes in little-endian order, at the destination.
- R4: An address whose advance flag is 1 steps by the beat's byte count after each beat. An address whose flag is 0 stays fixed, so a fixed destination ends up holding the last beat.
- R5: Width codes 0, 1, 2 and 3 give beats of 1, 2, 3 and 4 bytes.
- R6: A burst begins only in a cycle where `xfer_req` is 1. With `xfer_req` low between bursts, no memory request is issued.
- R7: A burst is burst code + 1 beats, issued without rechecking `xfer_req`. At the end of a descriptor the last burst is cut short. If the bytes left are fewer than the width, the final beat carries only those bytes.
- R8: A next index of 0 ends the chain. `done` is then high for exactly one cycle, `busy` is low in that same cycle, and the channel is idle again.
- R9: With `ring` set at start, a null next index wraps to the start descriptor. The transfer repeats and `done` never pulses.
- R10: `busy` is high from start until `done`. A `go` while busy is ignored.
- R11: With `GRAN`=2 (default), `residue` holds the bytes left in the current descriptor and is updated at each burst end; it returns to 0 when the chain ends. With `GRAN`=1 it shows the descriptor's full count until that descriptor finishes. With `GRAN`=0 it is all ones while busy.
- R12: While `mem_req` is high and `mem_ready` is low, the request, its address, direction and size hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dsc_wr | input | 1 | Descriptor memory write enable |
| dsc_addr | input | IW | Descriptor index to write |
| dsc_data | input | 60 | Descriptor word |
| go | input | 1 | Start pulse |
| go_idx | input | IW | Index of the first descriptor |
| ring | input | 1 | Ring mode, sampled at start |
| xfer_req | input | 1 | Peripheral transfer request |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Bytes in the beat minus one |
| mem_wdata | output | 32 | Write data, low lanes used |
| mem_rdata | input | 32 | Read data, low lanes used |
| mem_ready | input | 1 | Memory accepts the access |
| busy | output | 1 | Channel active |
| done | output | 1 | One-cycle end-of-chain pulse |
| residue | output | CW | Bytes still to move |

## Verification
The hardest state to reach from the ports is the channel parked partway through a descriptor. In that state one burst has finished, the residue shows a partial count, and no further request may be issued. The stimulus gets there by keeping `xfer_req` low after start. It then raises the line for exactly one cycle while the engine waits, and checks the write count and residue after a long quiet gap. A second descriptor sized so that its last burst holds a single beat is driven the same way, one pulse per burst. This checks that the engine cuts the burst short and ends with a one-cycle `done`. The memory model stalls `mem_ready` on a repeating pattern, so every beat also crosses wait cycles.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LOAD, S_WAIT, S_RD, S_WR, S_NEXT
  } sg_state_t;

  localparam int GRAN_XFER  = 0;
  localparam int GRAN_CHUNK = 1;
  localparam int GRAN_BURST = 2;
endpackage

// File: rtl/sgdma_desc_ram.sv
module sgdma_desc_ram #(
  parameter int W  = 60,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << IW;

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/sgdma_residue.sv
module sgdma_residue #(
  parameter int CW   = 16,
  parameter int GRAN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          load,
  input  logic [CW-1:0] load_cnt,
  input  logic          step,
  input  logic [CW-1:0] step_cnt,
  input  logic          chunk_end,
  input  logic          finish,
  output logic [CW-1:0] residue
);
  import sgdma_pkg::*;

  logic [CW-1:0] nxt;

  always_comb begin
    nxt = residue;
    if (finish)                          nxt = '0;
    else if (GRAN == GRAN_XFER) begin
      if (start)                         nxt = '1;
    end else if (load)                   nxt = load_cnt;
    else if (GRAN == GRAN_CHUNK) begin
      if (chunk_end)                     nxt = '0;
    end else if (step)                   nxt = step_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) residue <= '0;
    else     residue <= nxt;
  end

  // R11
  clear_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
    finish |=> (residue == '0));
endmodule

// File: rtl/sg_dma_chan.sv
module sg_dma_chan #(
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int IW   = 4,
  parameter int BLW  = 4,
  parameter int GRAN = 2,
  localparam int O_NXT  = 0,
  localparam int O_CNT  = O_NXT + IW,
  localparam int O_BL   = O_CNT + CW,
  localparam int O_WC   = O_BL + BLW,
  localparam int O_DI   = O_WC + 2,
  localparam int O_SI   = O_DI + 1,
  localparam int O_DST  = O_SI + 1,
  localparam int O_SRC  = O_DST + AW,
  localparam int DESC_W = O_SRC + AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dsc_wr,
  input  logic [IW-1:0]     dsc_addr,
  input  logic [DESC_W-1:0] dsc_data,
  input  logic              go,
  input  logic [IW-1:0]     go_idx,
  input  logic              ring,
  input  logic              xfer_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [1:0]        mem_size,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done,
  output logic [CW-1:0]     residue
);
  import sgdma_pkg::*;

  sg_state_t         st;
  logic [IW-1:0]     cur_idx, first_idx, nxt_q;
  logic [AW-1:0]     src_q, dst_q;
  logic              sinc_q, dinc_q, ring_q;
  logic [1:0]        wcode_q;
  logic [BLW-1:0]    blen_q;
  logic [CW-1:0]     rem_q;
  logic [BLW:0]      beats_q;
  logic [31:0]       data_q;
  logic [DESC_W-1:0] rd_word;
  logic              busy_q, done_q;

  logic [2:0]        wbytes, bsz;
  logic              last_beat, burst_end, beat_done, chain_end;

  sgdma_desc_ram #(.W(DESC_W), .IW(IW)) u_ram (
    .clk(clk), .we(dsc_wr), .waddr(dsc_addr), .wdata(dsc_data),
    .raddr(cur_idx), .rdata(rd_word)
  );

  always_comb begin
    wbytes    = {1'b0, wcode_q} + 3'd1;
    bsz       = (rem_q < CW'(wbytes)) ? rem_q[2:0] : wbytes;
    beat_done = (st == S_WR) && mem_ready;
    last_beat = (rem_q == CW'(bsz));
    burst_end = beat_done && (last_beat || beats_q == 1);
    chain_end = (st == S_NEXT) && (nxt_q == '0) && !ring_q;
  end

  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_WR) ? dst_q : src_q;
  assign mem_size  = 2'(bsz - 3'd1);
  assign mem_wdata = data_q;
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      cur_idx   <= '0;
      first_idx <= '0;
      nxt_q     <= '0;
      ring_q    <= 1'b0;
      src_q     <= '0;
      dst_q     <= '0;
      sinc_q    <= 1'b0;
      dinc_q    <= 1'b0;
      wcode_q   <= '0;
      blen_q    <= '0;
      rem_q     <= '0;
      beats_q   <= '0;
      data_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (go) begin
          cur_idx   <= go_idx;
          first_idx <= go_idx;
          ring_q    <= ring;
          busy_q    <= 1'b1;
          st        <= S_FETCH;
        end
        S_FETCH: st <= S_LOAD;
        S_LOAD: begin
          src_q   <= rd_word[O_SRC +: AW];
          dst_q   <= rd_word[O_DST +: AW];
          sinc_q  <= rd_word[O_SI];
          dinc_q  <= rd_word[O_DI];
          wcode_q <= rd_word[O_WC +: 2];
          blen_q  <= rd_word[O_BL +: BLW];
          rem_q   <= rd_word[O_CNT +: CW];
          nxt_q   <= rd_word[O_NXT +: IW];
          st      <= (rd_word[O_CNT +: CW] == '0) ? S_NEXT : S_WAIT;
        end
        S_WAIT: if (xfer_req) begin
          beats_q <= {1'b0, blen_q} + 1'b1;
          st      <= S_RD;
        end
        S_RD: if (mem_ready) begin
          data_q <= mem_rdata;
          st     <= S_WR;
        end
        S_WR: if (mem_ready) begin
          if (sinc_q) src_q <= src_q + AW'(bsz);
          if (dinc_q) dst_q <= dst_q + AW'(bsz);
          rem_q   <= rem_q - CW'(bsz);
          beats_q <= beats_q - 1'b1;
          if (last_beat)          st <= S_NEXT;
          else if (beats_q == 1)  st <= S_WAIT;
          else                    st <= S_RD;
        end
        S_NEXT: begin
          if (nxt_q != '0) begin
            cur_idx <= nxt_q;
            st      <= S_FETCH;
          end else if (ring_q) begin
            cur_idx <= first_idx;
            st      <= S_FETCH;
          end else begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  sgdma_residue #(.CW(CW), .GRAN(GRAN)) u_res (
    .clk(clk), .rst(rst),
    .start((st == S_IDLE) && go),
    .load(st == S_LOAD),
    .load_cnt(rd_word[O_CNT +: CW]),
    .step(burst_end),
    .step_cnt(rem_q - CW'(bsz)),
    .chunk_end(beat_done && last_beat),
    .finish(chain_end),
    .residue(residue)
  );

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R6
  req_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && !xfer_req) |=> !mem_req);
  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size)));
  // R10
  go_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && go) |=> (first_idx == $past(first_idx)));
  // R5
  size_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_size <= wcode_q));
endmodule

// File: tb/sim_sg_dma_chan.sv
module sim_sg_dma_chan;
  localparam int DW = 60;

  typedef struct packed {
    logic [15:0] src, dst;
    logic        si, di;
    logic [1:0]  wc;
    logic [3:0]  bl;
    logic [15:0] cnt;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{16'h000, 16'h200, 1'b1, 1'b1, 2'd0, 4'd3,  16'd13},
    '{16'h010, 16'h220, 1'b1, 1'b1, 2'd1, 4'd1,  16'd10},
    '{16'h020, 16'h240, 1'b1, 1'b1, 2'd2, 4'd0,  16'd11},
    '{16'h030, 16'h260, 1'b1, 1'b1, 2'd3, 4'd7,  16'd32},
    '{16'h040, 16'h280, 1'b1, 1'b0, 2'd3, 4'd2,  16'd12},
    '{16'h050, 16'h2A0, 1'b0, 1'b1, 2'd1, 4'd15, 16'd8}
  };

  logic clk = 0, rst = 1;
  logic dsc_wr = 0, go = 0, ring = 0, xfer_req = 0;
  logic [3:0] dsc_addr = 0, go_idx = 0;
  logic [DW-1:0] dsc_data = 0;
  logic mem_req, mem_we, mem_ready, busy, done;
  logic [15:0] mem_addr, residue;
  logic [1:0] mem_size;
  logic [31:0] mem_wdata, mem_rdata;

  logic [7:0] mem [1024];
  logic [7:0] exp_m [1024];
  logic init_go = 0;
  logic [1:0] rdy_cnt = 0;
  int wr_cnt = 0;
  logic [1:0] last_size = 0;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [9:0] a;

  always #5 clk = ~clk;

  sg_dma_chan u0 (
    .clk(clk), .rst(rst), .dsc_wr(dsc_wr), .dsc_addr(dsc_addr), .dsc_data(dsc_data),
    .go(go), .go_idx(go_idx), .ring(ring), .xfer_req(xfer_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .residue(residue)
  );

  assign a         = mem_addr[9:0];
  assign mem_rdata = {mem[a + 10'd3], mem[a + 10'd2], mem[a + 10'd1], mem[a]};
  assign mem_ready = mem_req && (rdy_cnt != 2'b11);

  always @(negedge clk) rdy_cnt <= rdy_cnt + 2'd1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (init_go) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (mem_req && mem_we && mem_ready) begin
      for (int k = 0; k < 4; k++)
        if (k <= int'(mem_size)) mem[a + 10'(k)] <= mem_wdata[8*k +: 8];
      wr_cnt    <= wr_cnt + 1;
      last_size <= mem_size;
    end
  end

  always @(negedge clk) if (cyc > 150000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic put_desc(input int idx, input logic [15:0] s, d, input logic si, di,
                          input logic [1:0] wc, input logic [3:0] bl,
                          input logic [15:0] cnt, input logic [3:0] nx);
    @(negedge clk);
    dsc_wr = 1; dsc_addr = 4'(idx);
    dsc_data = {s, d, si, di, wc, bl, cnt, nx};
    @(negedge clk);
    dsc_wr = 0;
  endtask

  // Reference copy into exp_m; returns beat count and last beat size code
  task automatic model(input logic [15:0] s0, d0, input logic si, di,
                       input logic [1:0] wc, input logic [15:0] cnt,
                       output int nbeat, output int lsz);
    int s = int'(s0), d = int'(d0), r = int'(cnt), w = int'(wc) + 1;
    nbeat = 0; lsz = 0;
    while (r > 0) begin
      int b = (r < w) ? r : w;
      for (int k = 0; k < b; k++) exp_m[(d + k) % 1024] = exp_m[(s + k) % 1024];
      if (si) s += b;
      if (di) d += b;
      r -= b; nbeat++; lsz = b - 1;
    end
  endtask

  task automatic pulse_go(input int idx);
    @(negedge clk);
    go = 1; go_idx = 4'(idx);
    @(negedge clk);
    go = 0;
  endtask

  task automatic wait_done(input int lim, output int dn);
    int t = 0;
    dn = 0;
    while (dn == 0 && t < lim) begin
      @(negedge clk); t++;
      if (done) dn++;
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (done) dn++;
    end
  endtask

  function automatic int mem_diff();
    int n = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== exp_m[i]) n++;
    return n;
  endfunction

  initial begin
    int nb, ls, dn, base;
    for (int i = 0; i < 1024; i++) exp_m[i] = 8'(i * 7 + 3);
    @(negedge clk); init_go = 1;
    @(negedge clk); init_go = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_req, "R1 idle flags", {busy, done, mem_req}, 0);
    chk(residue == 0, "R1 residue", residue, 0);

    // Table: R2 R3 R4 R5 R7 R8
    xfer_req = 1;
    for (int v = 0; v < 6; v++) begin
      put_desc(1, VEC[v].src, VEC[v].dst, VEC[v].si, VEC[v].di, VEC[v].wc, VEC[v].bl, VEC[v].cnt, 0);
      model(VEC[v].src, VEC[v].dst, VEC[v].si, VEC[v].di, VEC[v].wc, VEC[v].cnt, nb, ls);
      base = wr_cnt;
      pulse_go(1);
      wait_done(2000, dn);
      chk(dn == 1, "R8 single done pulse", dn, 1);
      chk(mem_diff() == 0, "R3 R4 memory contents", mem_diff(), 0);
      chk(wr_cnt - base == nb, "R5 beat count", wr_cnt - base, nb);
      chk(int'(last_size) == ls, "R7 last beat size", last_size, ls);
    end
    chk(residue == 0 && !busy, "R11 residue cleared at end", residue, 0);

    // Stall between bursts: R6 R7 R11
    xfer_req = 0;
    put_desc(6, 16'h060, 16'h300, 1, 1, 2'd0, 4'd3, 16'd20, 0);
    model(16'h060, 16'h300, 1, 1, 2'd0, 16'd20, nb, ls);
    base = wr_cnt;
    pulse_go(6);
    repeat (10) @(negedge clk);
    chk(wr_cnt == base && !mem_req, "R6 no access without request", wr_cnt - base, 0);
    chk(residue == 20, "R11 residue after load", residue, 20);
    xfer_req = 1; @(negedge clk); xfer_req = 0;
    repeat (40) @(negedge clk);
    chk(wr_cnt - base == 4, "R7 one burst of four beats", wr_cnt - base, 4);
    chk(residue == 16, "R11 residue after burst", residue, 16);
    chk(busy == 1, "R10 busy while parked", busy, 1);
    xfer_req = 1;
    wait_done(2000, dn);
    chk(dn == 1 && mem_diff() == 0, "R6 completion after stall", mem_diff(), 0);

    // Truncated final burst: R7 R11
    xfer_req = 0;
    put_desc(5, 16'h0B0, 16'h340, 1, 1, 2'd1, 4'd3, 16'd10, 0);
    model(16'h0B0, 16'h340, 1, 1, 2'd1, 16'd10, nb, ls);
    base = wr_cnt;
    pulse_go(5);
    repeat (6) @(negedge clk);
    xfer_req = 1; @(negedge clk); xfer_req = 0;
    repeat (40) @(negedge clk);
    chk(wr_cnt - base == 4 && residue == 2, "R11 residue two bytes left", residue, 2);
    xfer_req = 1; @(negedge clk); xfer_req = 0;
    wait_done(200, dn);
    chk(wr_cnt - base == 5, "R7 short last burst", wr_cnt - base, 5);
    chk(dn == 1 && mem_diff() == 0, "R7 short burst data", mem_diff(), 0);

    // Linked chain with ignored go: R2 R8 R10
    xfer_req = 1;
    put_desc(1, 16'h070, 16'h310, 1, 1, 2'd0, 4'd1, 16'd5, 2);
    put_desc(2, 16'h080, 16'h320, 1, 1, 2'd3, 4'd0, 16'd8, 3);
    put_desc(3, 16'h090, 16'h330, 1, 1, 2'd2, 4'd2, 16'd9, 0);
    put_desc(7, 16'h0C0, 16'h380, 1, 1, 2'd3, 4'd3, 16'd16, 0);
    model(16'h070, 16'h310, 1, 1, 2'd0, 16'd5, nb, ls);
    model(16'h080, 16'h320, 1, 1, 2'd3, 16'd8, nb, ls);
    model(16'h090, 16'h330, 1, 1, 2'd2, 16'd9, nb, ls);
    pulse_go(1);
    repeat (4) @(negedge clk);
    chk(busy == 1, "R10 busy during chain", busy, 1);
    pulse_go(7);
    wait_done(3000, dn);
    chk(dn == 1 && !busy, "R8 chain ends once", dn, 1);
    chk(mem_diff() == 0, "R10 R2 chain data, ignored go left no trace", mem_diff(), 0);

    // Ring mode: R9
    put_desc(8, 16'h0A0, 16'h3C0, 1, 1, 2'd0, 4'd3, 16'd4, 9);
    put_desc(9, 16'h0A4, 16'h3C4, 1, 1, 2'd0, 4'd3, 16'd4, 0);
    model(16'h0A0, 16'h3C0, 1, 1, 2'd0, 16'd4, nb, ls);
    model(16'h0A4, 16'h3C4, 1, 1, 2'd0, 16'd4, nb, ls);
    base = wr_cnt;
    ring = 1;
    pulse_go(8);
    ring = 0;
    dn = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (done) dn++;
    end
    chk(wr_cnt - base > 16, "R9 ring keeps looping", wr_cnt - base, 17);
    chk(dn == 0 && busy, "R9 no done in ring mode", dn, 0);
    chk(mem_diff() == 0, "R9 ring data", mem_diff(), 0);

    // Reset out of ring: R1
    rst = 1; xfer_req = 0;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !mem_req && residue == 0, "R1 reset ends ring", busy, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule